// File: doc/BRIEF.md
# Adjustable Conversion Timing Generator

This block produces the timing for a converter pair from one master clock. It makes three outputs. The first is a serial shift clock at one quarter of the master rate. The second is a switched-capacitor filter clock. The third is a one-cycle conversion strobe. Two counters are chained to make the last two. The first counter divides the master clock by a programmable value A, and the filter clock toggles each time that counter expires. The second counter counts whole filter clock periods and fires the strobe after B of them. The nominal conversion period is therefore 2·A·B master clocks.

Software can move one conversion earlier or later. It does this by posting an adjust command, which is captured when a load strobe is given. At the next conversion event, counter A is reloaded with A minus the offset or A plus the offset in place of A. That shortens or lengthens the following conversion period by the offset in master clocks. The command is then dropped, so later periods are nominal again. The register values are plain level inputs, and each counter picks up the current value whenever it reloads. The block has no streaming data interface, so every pin is a plain control or clock signal and there is no back-pressure.

Top module: `conv_timing_gen`

## Requirements
- R1: `shift_clk_o` has a period of 4 master clocks with 50% duty. It reads 0 after the first edge following reset release, then 1 after the second and third edges, then 0 after the fourth, and repeats this pattern.
- R2: `filt_clk_o` is 1 during reset and falls on the first edge after release. After that it toggles every A master clocks, so its period is 2·A.
- R3: An A value of 0 is treated as 1.
- R4: `conv_o` is high for exactly one master clock. The first pulse follows the first edge after reset release. Consecutive pulses are 2·A·B master clocks apart when no adjustment is pending.
- R5: A B value of 0 is treated as 1.
- R6: While `rst_ni` is low, `shift_clk_o` is 0, `filt_clk_o` is 1 and `conv_o` is 0.
- R7: `adj_cmd_i` is encoded as 2'b01 for advance, 2'b10 for retard, and 2'b00 or 2'b11 for none. It is captured when `adj_load_i` is high. With advance pending, the period that begins at the next conversion pulse is shorter by the offset, and the period that ends at that pulse is unchanged.
- R8: With retard pending, the period that begins at the next conversion pulse is longer by the offset.
- R9: An adjustment applies to one period only. The period after the adjusted one is 2·A·B again without any further command.
- R10: An adjusted counter A reload that works out to zero or less is clamped to 1.
- R11: A later load replaces a pending command. Loading the none code, either 2'b00 or 2'b11, cancels a pending adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset |
| a_val_i | input | 8 | Counter A divide value |
| a_ofs_i | input | 8 | Offset applied on an adjusted reload |
| b_val_i | input | 8 | Counter B divide value (filter periods per conversion) |
| adj_load_i | input | 1 | Captures `adj_cmd_i` into the pending command |
| adj_cmd_i | input | 2 | Adjust command: 01 advance, 10 retard, else none |
| shift_clk_o | output | 1 | Master clock divided by 4 |
| filt_clk_o | output | 1 | Filter clock, period 2·A |
| conv_o | output | 1 | One-cycle conversion strobe |

## Verification
All outputs are registered. Each one changes on the edge where its counter reaches terminal count, so the bench samples on the falling edge and numbers the edges from reset release. Within that numbering, the first strobe is due at edge 1, the filter clock falls at edge 1, and the shift clock first rises at edge 2. Periods are measured as the number of falling-edge samples between strobes. A changed A or B is only trusted after two discarded periods. An adjust command is posted right after a strobe. The next interval must therefore still be nominal, the one after it must be shifted by the offset, and the third must be nominal again.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'b00,
    ADJ_EARLY = 2'b01,
    ADJ_LATE  = 2'b10
  } adj_e;

  function automatic adj_e decode_adj(input logic [1:0] code);
    case (code)
      2'b01:   return ADJ_EARLY;
      2'b10:   return ADJ_LATE;
      default: return ADJ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ctg_shift_div.sv
module ctg_shift_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic shift_clk_o
);
  logic [DIV_LOG2-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + 1'b1;
  end

  assign shift_clk_o = ph_q[DIV_LOG2-1];

  generate
    if (DIV_LOG2 > 1) begin : g_chk
      // R1: each level of the shift clock lasts more than one master clock
      a_r1_shift_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(shift_clk_o) |=> shift_clk_o);
    end
  endgenerate
endmodule

// File: rtl/ctg_adj_ctrl.sv
module ctg_adj_ctrl
  import ctg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] cmd_i,
  input  logic       consume_i,
  output adj_e       mode_o
);
  adj_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= ADJ_NONE;
    else if (load_i)    mode_q <= decode_adj(cmd_i);
    else if (consume_i) mode_q <= ADJ_NONE;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/ctg_ctr_a.sv
module ctg_ctr_a
  import ctg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] ofs_i,
  input  adj_e         mode_i,
  input  logic         conv_evt_i,
  output logic         a_tc_o,
  output logic         filt_o
);
  localparam int CW = W + 1;
  localparam int SW = W + 2;

  logic [CW-1:0]        cnt_q, a_base, reload;
  logic signed [SW-1:0] adj_sum;
  logic                 filt_q;

  always_comb begin
    a_base  = (a_i == '0) ? CW'(1) : CW'(a_i);
    adj_sum = $signed({1'b0, a_base});
    if (mode_i == ADJ_EARLY)     adj_sum = $signed({1'b0, a_base}) - $signed({2'b00, ofs_i});
    else if (mode_i == ADJ_LATE) adj_sum = $signed({1'b0, a_base}) + $signed({2'b00, ofs_i});
    if (conv_evt_i && mode_i != ADJ_NONE)
      reload = (adj_sum < 1) ? CW'(1) : CW'(adj_sum);
    else
      reload = a_base;
  end

  assign a_tc_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(1);
      filt_q <= 1'b1;
    end else if (a_tc_o) begin
      cnt_q  <= reload;
      filt_q <= ~filt_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R2: the filter clock moves only when counter A expires
  a_r2_filt_on_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_tc_o |=> $stable(filt_q));
  // R10: counter A never holds zero, even after a clamped reload
  a_r10_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/ctg_ctr_b.sv
module ctg_ctr_b #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] b_i,
  input  logic         tick_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, b_eff;

  assign b_eff  = (b_i == '0) ? W'(1) : b_i;
  assign last_o = (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= W'(1);
    else if (tick_i) cnt_q <= last_o ? b_eff : cnt_q - 1'b1;
  end

  // R5: counter B never holds zero
  a_r5_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/conv_timing_gen.sv
module conv_timing_gen
  import ctg_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIV_LOG2 = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_val_i,
  input  logic [W-1:0] a_ofs_i,
  input  logic [W-1:0] b_val_i,
  input  logic         adj_load_i,
  input  logic [1:0]   adj_cmd_i,
  output logic         shift_clk_o,
  output logic         filt_clk_o,
  output logic         conv_o
);
  adj_e mode;
  logic a_tc, filt, b_last, conv_evt, conv_q;

  ctg_shift_div #(.DIV_LOG2(DIV_LOG2)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_clk_o(shift_clk_o));

  ctg_adj_ctrl u_adj (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(adj_load_i), .cmd_i(adj_cmd_i),
    .consume_i(conv_evt), .mode_o(mode));

  ctg_ctr_a #(.W(W)) u_ctr_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_val_i), .ofs_i(a_ofs_i),
    .mode_i(mode), .conv_evt_i(conv_evt), .a_tc_o(a_tc), .filt_o(filt));

  // counter B advances once per full filter period (on the falling toggle)
  ctg_ctr_b #(.W(W)) u_ctr_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .b_i(b_val_i), .tick_i(a_tc && filt),
    .last_o(b_last));

  assign conv_evt = a_tc && filt && b_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= conv_evt;
  end

  assign filt_clk_o = filt;
  assign conv_o     = conv_q;

  // R4: the strobe lasts a single master clock
  a_r4_conv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);
  // R9: a conversion event without a new load leaves no command pending
  a_r9_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_evt && !adj_load_i) |=> (mode == ADJ_NONE));
  // R4: a strobe is always preceded by the filter clock falling
  a_r4_conv_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $fell(filt_clk_o));
endmodule

// File: tb/conv_timing_gen_tb.sv
module conv_timing_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_val = 8'd3, a_ofs = 8'd0, b_val = 8'd2;
  logic       adj_load = 1'b0;
  logic [1:0] adj_cmd = 2'b00;
  logic       shift_clk, filt_clk, conv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  conv_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_val_i(a_val), .a_ofs_i(a_ofs),
    .b_val_i(b_val), .adj_load_i(adj_load), .adj_cmd_i(adj_cmd),
    .shift_clk_o(shift_clk), .filt_clk_o(filt_clk), .conv_o(conv));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling-edge samples until the next strobe; clears the load strobe
  task automatic measure(output int n);
    @(negedge clk);
    n = 1;
    adj_load = 1'b0;
    while (!conv && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!conv) chk("R4 strobe timeout", 0, 1);
  endtask

  task automatic set_regs(input int a, input int b, input int o);
    int d;
    a_val = 8'(a); b_val = 8'(b); a_ofs = 8'(o);
    measure(d);
    measure(d);
  endtask

  task automatic t_reset();
    a_val = 8'd3; b_val = 8'd2;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 shift in reset", shift_clk, 0);
    chk("R6 filt in reset", filt_clk, 1);
    chk("R6 conv in reset", conv, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      chk("R1 shift pattern", shift_clk, (k >> 1) & 1);
      chk("R2 filt half period", filt_clk, (((k - 1) / 3) % 2 == 0) ? 0 : 1);
      chk("R4 first strobes", conv, (k == 1 || k == 13) ? 1 : 0);
    end
  endtask

  task automatic t_width();
    int n;
    measure(n);
    @(negedge clk);
    chk("R4 strobe width", conv, 0);
    measure(n);
  endtask

  task automatic t_period(input string req, input int a, input int b, input int exp);
    int n;
    set_regs(a, b, 0);
    measure(n);
    chk(req, n, exp);
  endtask

  task automatic t_adjust(input string req, input int a, input int b, input int o,
                          input logic [1:0] cmd, input int delta);
    int n;
    set_regs(a, b, o);
    adj_cmd = cmd; adj_load = 1'b1;
    measure(n);
    chk({req, " period before use"}, n, 2 * a * b);
    measure(n);
    chk({req, " adjusted period"}, n, 2 * a * b + delta);
    measure(n);
    chk("R9 back to nominal", n, 2 * a * b);
  endtask

  task automatic t_cancel();
    int n;
    set_regs(4, 2, 3);
    adj_cmd = 2'b01; adj_load = 1'b1;
    @(negedge clk);
    adj_cmd = 2'b00;
    measure(n);
    chk("R11 cancel pre", n, 15);
    measure(n);
    chk("R11 cancel by none", n, 16);
  endtask

  initial begin
    t_reset();
    t_width();
    t_period("R4 period a3 b2", 3, 2, 12);
    t_period("R4 period a1 b1", 1, 1, 2);
    t_period("R4 period a5 b3", 5, 3, 30);
    t_period("R3 zero A", 0, 2, 4);
    t_period("R5 zero B", 2, 0, 4);
    t_adjust("R7 advance", 4, 2, 3, 2'b01, -3);
    t_adjust("R8 retard", 3, 2, 5, 2'b10, 5);
    t_adjust("R10 clamp", 5, 2, 9, 2'b01, -4);
    t_adjust("R11 code 11 is none", 4, 2, 3, 2'b11, 0);
    t_cancel();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule